// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This unit orders two IEEE-754 values of half, single or double width and reports the outcome as a four-bit condition code. It returns no numeric result. A 2-bit size code selects the format. Narrower formats take their operand from the low bits of each 64-bit bus, and the upper bits are ignored. A zero-compare select replaces the second operand with positive zero of the active format. A quiet-NaN control decides whether a quiet NaN counts as an invalid operation. A signaling NaN always counts as one.

The result is written into a 32-bit status word. The caller presents the current status word on `stat_in` together with a compare request. One clock later the unit returns the updated word with the condition code in its top four bits and the invalid-operation flag beside it. The ordering uses only sign-magnitude integer comparison of the raw bit patterns, with no subtraction. Subnormal values are ordered by magnitude and are never flushed to zero.

Top module: `fp_cmp_flags`

## Requirements
- R1: `fmt_sel` picks the format: 2'b01 half (sign bit 15, exponent 14:10, fraction 9:0), 2'b10 single (sign 31, exponent 30:23, fraction 22:0), 2'b11 double (sign 63, exponent 62:52, fraction 51:0). For half and single, operand bits above the format width have no effect.
- R2: When `zero_mode` is 1, `opb` is ignored and the first operand is compared against +0.0 of the active format.
- R3: A request (`cmp_valid`=1 with a legal size code) raises `done_out` on the next clock edge. On that same edge `stat_out[31:28]` takes the code, with N at bit 31 and V at bit 28, and `stat_out[27:0]` takes `stat_in[27:0]` from the request cycle.
- R4: Equal operands give code 4'b0110. +0 and -0 compare equal.
- R5: An ordered compare gives 4'b1000 when the first operand is less than the second and 4'b0010 when it is greater. Negative values, infinities and subnormals order by sign and magnitude.
- R6: If either operand is a NaN (all-ones exponent, nonzero fraction), the result is unordered and gives 4'b0110's counterpart 4'b0011, so C and V are both set.
- R7: `invalid_out` is 1 after any request in which an operand is a signaling NaN (top fraction bit 0), in every mode.
- R8: A quiet NaN (top fraction bit 1) sets `invalid_out` only when `qnan_exc_en` is 1. Otherwise `invalid_out` is 0 after an ordered compare.
- R9: Reset clears `stat_out`, `invalid_out` and `done_out`. Outside an accepted request, `stat_out` and `invalid_out` hold their values and `done_out` is 0.
- R10: Size code 2'b00 is reserved. A request carrying it is ignored: `done_out` stays 0 and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Compare request this cycle |
| fmt_sel | input | 2 | Size code: 01 half, 10 single, 11 double, 00 reserved |
| opa | input | 64 | First operand (low bits for narrow formats) |
| opb | input | 64 | Second operand (low bits for narrow formats) |
| zero_mode | input | 1 | Compare the first operand against +0.0 |
| qnan_exc_en | input | 1 | Quiet NaN also raises invalid operation |
| stat_in | input | 32 | Current status word |
| stat_out | output | 32 | Updated status word, condition code in bits 31:28 |
| invalid_out | output | 1 | Invalid-operation flag of the last accepted compare |
| done_out | output | 1 | One-cycle pulse after an accepted request |

## Verification
The assertions check the following on every cycle:
- the latency and acceptance of requests, including rejection of the reserved size code;
- that the low status bits pass through unchanged;
- that the code is always one of the four legal values;
- that a NaN seen by the unpack stage forces the unordered code;
- that a signaling NaN always raises invalid;
- that the outputs hold between requests.

Only the bench scenarios can show the following:
- the actual ordering, such as the signed-zero equality, negative and subnormal ordering and infinities;
- that the upper bus bits are ignored in narrow formats;
- that substituted zero replaces `opb`.

The bench shows these by comparing each result with its own ordering-key model.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int OPW  = 64;
  localparam int CCW  = 4;
  localparam int H_EW = 5;
  localparam int H_FW = 10;
  localparam int S_EW = 8;
  localparam int S_FW = 23;
  localparam int D_EW = 11;
  localparam int D_FW = 52;

  typedef enum logic [1:0] {
    FMT_RSVD = 2'b00,
    FMT_HALF = 2'b01,
    FMT_SNGL = 2'b10,
    FMT_DBL  = 2'b11
  } fmt_e;

  localparam logic [CCW-1:0] CC_EQ = 4'b0110;
  localparam logic [CCW-1:0] CC_LT = 4'b1000;
  localparam logic [CCW-1:0] CC_GT = 4'b0010;
  localparam logic [CCW-1:0] CC_UN = 4'b0011;

  typedef struct packed {
    logic           sign;
    logic [OPW-2:0] mag;
    logic           is_nan;
    logic           is_snan;
    logic           is_zero;
  } fp_fields_t;

  // Split a raw pattern into sign, magnitude and class for given field widths
  function automatic fp_fields_t split_w(logic [OPW-1:0] raw, int unsigned ew, int unsigned fw);
    fp_fields_t     f;
    logic [OPW-1:0] ones;
    logic [OPW-1:0] frac;
    logic [OPW-1:0] expf;
    logic [OPW-1:0] absv;
    ones      = '1;
    frac      = raw & ~(ones << fw);
    expf      = (raw >> fw) & ~(ones << ew);
    absv      = raw & ~(ones << (ew + fw));
    f.sign    = raw[ew+fw];
    f.mag     = absv[OPW-2:0];
    f.is_nan  = (expf == ~(ones << ew)) && (frac != '0);
    f.is_snan = f.is_nan && !raw[fw-1];
    f.is_zero = (absv == '0);
    return f;
  endfunction

  // Sign-magnitude ordering of two unpacked operands
  function automatic logic [CCW-1:0] order_cc(fp_fields_t a, fp_fields_t b);
    logic mag_lt;
    mag_lt = (a.mag < b.mag);
    if (a.is_nan || b.is_nan)                        return CC_UN;
    else if (a.is_zero && b.is_zero)                 return CC_EQ;
    else if ((a.sign == b.sign) && (a.mag == b.mag)) return CC_EQ;
    else if (a.sign != b.sign)                       return a.sign ? CC_LT : CC_GT;
    else if (!a.sign)                                return mag_lt ? CC_LT : CC_GT;
    else                                             return mag_lt ? CC_GT : CC_LT;
  endfunction

  function automatic logic invalid_op(fp_fields_t a, fp_fields_t b, logic qnan_en);
    return a.is_snan || b.is_snan || (qnan_en && (a.is_nan || b.is_nan));
  endfunction
endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
  import fpcmp_pkg::*;
(
  input  fmt_e             fmt,
  input  logic [OPW-1:0]   raw,
  output fp_fields_t       fld
);
  always_comb begin
    case (fmt)
      FMT_HALF: fld = split_w(raw, H_EW, H_FW);
      FMT_SNGL: fld = split_w(raw, S_EW, S_FW);
      default:  fld = split_w(raw, D_EW, D_FW);
    endcase
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  fp_fields_t     a,
  input  fp_fields_t     b,
  input  logic           qnan_en,
  output logic [CCW-1:0] cc,
  output logic           inv
);
  always_comb begin
    cc  = order_cc(a, b);
    inv = invalid_op(a, b, qnan_en);
  end
endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
  import fpcmp_pkg::*;
#(
  parameter  int STW      = 32,
  localparam int FLAG_LSB = STW - CCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_valid,
  input  logic [1:0]      fmt_sel,
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  input  logic            zero_mode,
  input  logic            qnan_exc_en,
  input  logic [STW-1:0]  stat_in,
  output logic [STW-1:0]  stat_out,
  output logic            invalid_out,
  output logic            done_out
);
  logic [OPW-1:0] opnd [2];
  fp_fields_t     fld  [2];
  logic [CCW-1:0] cc_w;
  logic           inv_w;
  logic           accept_w;
  logic           nan_any_w;
  logic           snan_any_w;

  assign opnd[0] = opa;
  assign opnd[1] = zero_mode ? '0 : opb;

  for (genvar k = 0; k < 2; k++) begin : g_unp
    fpcmp_unpack u_unp (
      .fmt (fmt_e'(fmt_sel)),
      .raw (opnd[k]),
      .fld (fld[k])
    );
  end

  fpcmp_order u_ord (
    .a       (fld[0]),
    .b       (fld[1]),
    .qnan_en (qnan_exc_en),
    .cc      (cc_w),
    .inv     (inv_w)
  );

  assign accept_w   = cmp_valid && (fmt_sel != FMT_RSVD);
  assign nan_any_w  = fld[0].is_nan  || fld[1].is_nan;
  assign snan_any_w = fld[0].is_snan || fld[1].is_snan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_out    <= '0;
      invalid_out <= 1'b0;
      done_out    <= 1'b0;
    end else begin
      done_out <= accept_w;
      if (accept_w) begin
        stat_out    <= {cc_w, stat_in[FLAG_LSB-1:0]};
        invalid_out <= inv_w;
      end
    end
  end
endmodule

// File: rtl/fp_cmp_flags_chk.sv
module fp_cmp_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmp_valid,
  input logic [1:0]  fmt_sel,
  input logic        qnan_exc_en,
  input logic [31:0] stat_in,
  input logic [31:0] stat_out,
  input logic        invalid_out,
  input logic        done_out,
  input logic        nan_any_w,
  input logic        snan_any_w
);
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && fmt_sel != 2'b00) |=> done_out);

  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_valid && fmt_sel != 2'b00) |=> !done_out);

  assert_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_out |-> stat_out[27:0] == $past(stat_in[27:0]));

  assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_out |-> (stat_out[31:28] inside {4'b0110, 4'b1000, 4'b0010, 4'b0011}));

  assert_unordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_out && $past(nan_any_w)) |-> stat_out[31:28] == 4'b0011);

  assert_snan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_out && $past(snan_any_w)) |-> invalid_out);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_out && !$past(snan_any_w) && !$past(qnan_exc_en)) |-> !invalid_out);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_out |-> ($stable(stat_out) && $stable(invalid_out)));
endmodule

bind fp_cmp_flags fp_cmp_flags_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_valid   (cmp_valid),
  .fmt_sel     (fmt_sel),
  .qnan_exc_en (qnan_exc_en),
  .stat_in     (stat_in),
  .stat_out    (stat_out),
  .invalid_out (invalid_out),
  .done_out    (done_out),
  .nan_any_w   (nan_any_w),
  .snan_any_w  (snan_any_w)
);

// File: tb/sim_fp_cmp_flags.sv
`timescale 1ns/1ps
module sim_fp_cmp_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [1:0]  fmt_sel = 2'b11;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        zero_mode = 1'b0;
  logic        qnan_exc_en = 1'b0;
  logic [31:0] stat_in = '0;
  logic [31:0] stat_out;
  logic        invalid_out;
  logic        done_out;
  int n_chk = 0;
  int n_bad = 0;

  localparam logic [3:0] EQ = 4'b0110, LT = 4'b1000, GT = 4'b0010, UN = 4'b0011;

  always #2 clk = ~clk;

  fp_cmp_flags u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .fmt_sel(fmt_sel),
    .opa(opa), .opb(opb), .zero_mode(zero_mode), .qnan_exc_en(qnan_exc_en),
    .stat_in(stat_in), .stat_out(stat_out), .invalid_out(invalid_out),
    .done_out(done_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: total-order keys on MSB-aligned patterns
  function automatic logic [4:0] ref_cmp(logic [1:0] f, logic [63:0] a, logic [63:0] b, logic zm, logic qe);
    int w;
    int ew;
    logic [63:0] xa, xb, aa, ab, inf_abs, ka, kb;
    logic na, nb, sa, sb, inv;
    logic [3:0] cc;
    case (f)
      2'b01:   begin w = 16; ew = 5;  end
      2'b10:   begin w = 32; ew = 8;  end
      default: begin w = 64; ew = 11; end
    endcase
    xa = a << (64 - w);
    xb = zm ? 64'h0 : (b << (64 - w));
    aa = xa << 1;
    ab = xb << 1;
    inf_abs = ~(64'hFFFF_FFFF_FFFF_FFFF >> ew);
    na = aa > inf_abs;
    nb = ab > inf_abs;
    sa = na && !aa[63-ew];
    sb = nb && !ab[63-ew];
    inv = sa || sb || (qe && (na || nb));
    ka = xa[63] ? ~xa : (xa | 64'h8000_0000_0000_0000);
    kb = xb[63] ? ~xb : (xb | 64'h8000_0000_0000_0000);
    if (na || nb)                  cc = UN;
    else if (aa == 0 && ab == 0)   cc = EQ;
    else if (ka == kb)             cc = EQ;
    else if (ka < kb)              cc = LT;
    else                           cc = GT;
    return {cc, inv};
  endfunction

  // One compare; result sampled one cycle later at the falling edge
  task automatic run(input string tag, input logic [1:0] f, input logic [63:0] a, input logic [63:0] b,
                     input logic zm, input logic qe, input logic [31:0] s,
                     input logic [3:0] exp_cc, input logic exp_inv);
    @(negedge clk);
    fmt_sel = f; opa = a; opb = b; zero_mode = zm; qnan_exc_en = qe; stat_in = s;
    cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    stat_in = ~s;
    chk(done_out == 1'b1, {tag, " R3 done"}, 64'(done_out), 64'd1);
    chk(stat_out == {exp_cc, s[27:0]}, {tag, " R3 status"}, 64'(stat_out), 64'({exp_cc, s[27:0]}));
    chk(invalid_out == exp_inv, {tag, " invalid"}, 64'(invalid_out), 64'(exp_inv));
  endtask

  task automatic t_reset();
    chk(stat_out == 0 && !invalid_out && !done_out, "R9 reset", 64'({stat_out, invalid_out, done_out}), 64'd0);
  endtask

  task automatic t_formats();
    // R1 half with junk in upper bits; R5 ordering
    run("R1 half lt", 2'b01, 64'hDEAD_BEEF_0000_3C00, 64'h1234_5678_9ABC_4000, 0, 0, 32'h0ABC_DEF1, LT, 0);
    run("R1 single gt", 2'b10, 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_C000_0000, 0, 0, 32'h0000_0055, GT, 0);
    run("R5 double neg", 2'b11, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, 0, 0, 32'h0FFF_FFFF, LT, 0);
    run("R5 subnormal", 2'b11, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001, 0, 0, 32'h0, GT, 0);
    run("R5 -inf", 2'b10, 64'h0000_0000_FF80_0000, 64'h0000_0000_C000_0000, 0, 0, 32'h0, LT, 0);
    run("R4 inf eq", 2'b01, 64'h7C00, 64'h7C00, 0, 0, 32'h0, EQ, 0);
  endtask

  task automatic t_zeros();
    run("R4 +0/-0 half", 2'b01, 64'h8000, 64'h0000, 0, 0, 32'h1, EQ, 0);
    run("R4 -0/+0 dbl", 2'b11, 64'h8000_0000_0000_0000, 64'h0, 0, 0, 32'h2, EQ, 0);
    run("R2 zero mode", 2'b10, 64'h0000_0000_8000_0001, 64'h0000_0000_BF80_0000, 1, 0, 32'h3, LT, 0);
    run("R2 zero eq", 2'b11, 64'h0, 64'hFFF0_0000_0000_0000, 1, 0, 32'h4, EQ, 0);
  endtask

  task automatic t_nans();
    run("R6 qnan", 2'b11, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0, 0, 32'h5, UN, 0);
    run("R8 qnan en", 2'b11, 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0000, 0, 1, 32'h6, UN, 1);
    run("R7 snan half", 2'b01, 64'h3C00, 64'h7C01, 0, 0, 32'h7, UN, 1);
    run("R7 snan zm", 2'b10, 64'h0000_0000_7F80_0001, 64'h0, 1, 0, 32'h8, UN, 1);
    run("R8 clear", 2'b10, 64'h3F80_0000, 64'h3F80_0000, 0, 1, 32'h9, EQ, 0);
  endtask

  task automatic t_hold();
    logic [31:0] s0;
    logic        i0;
    run("R7 prep", 2'b01, 64'h7C01, 64'h0, 0, 0, 32'h0123_4567, UN, 1);
    s0 = stat_out; i0 = invalid_out;
    @(negedge clk);
    fmt_sel = 2'b11; opa = 64'h1; opb = 64'h2; stat_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk(stat_out == s0 && invalid_out == i0 && !done_out, "R9 hold idle", 64'(stat_out), 64'(s0));
    fmt_sel = 2'b00; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    chk(!done_out, "R10 reserved done", 64'(done_out), 64'd0);
    chk(stat_out == s0 && invalid_out == i0, "R10 reserved hold", 64'(stat_out), 64'(s0));
  endtask

  function automatic logic [63:0] pat(logic [1:0] f, int i);
    case (f)
      2'b01: case (i)
        0: return 64'h0000; 1: return 64'h8000; 2: return 64'h3C00; 3: return 64'hBC00;
        4: return 64'h0001; 5: return 64'hFC00; 6: return 64'h7E00; default: return 64'h7C01;
      endcase
      2'b10: case (i)
        0: return 64'h0000_0000; 1: return 64'h8000_0000; 2: return 64'h3F80_0000; 3: return 64'hBF80_0000;
        4: return 64'h0000_0001; 5: return 64'hFF80_0000; 6: return 64'h7FC0_0000; default: return 64'h7F80_0001;
      endcase
      default: case (i)
        0: return 64'h0; 1: return 64'h8000_0000_0000_0000; 2: return 64'h3FF0_0000_0000_0000;
        3: return 64'hBFF0_0000_0000_0000; 4: return 64'h1; 5: return 64'hFFF0_0000_0000_0000;
        6: return 64'h7FF8_0000_0000_0000; default: return 64'h7FF0_0000_0000_0001;
      endcase
    endcase
  endfunction

  task automatic t_sweep();
    for (int f = 1; f < 4; f++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [63:0] a, b, junk;
          logic [4:0]  r;
          logic        qe, zm;
          junk = (f == 1) ? 64'hA5A5_A5A5_A5A5_0000 : (f == 2) ? 64'h5A5A_5A5A_0000_0000 : 64'h0;
          a  = pat(2'(f), i) | junk;
          b  = pat(2'(f), j) | junk;
          qe = ((i + j) % 2) == 1;
          zm = (j == 7) && (i % 3 == 0);
          r  = ref_cmp(2'(f), a, b, zm, qe);
          run("R5 R6 R7 R8 sweep", 2'(f), a, b, zm, qe, 32'(i * 97 + j * 13 + f), r[4:1], r[0]);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_zeros();
    t_nans();
    t_hold();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule